// File: doc/BRIEF.md
# Watermark Pause-Frame Request Generator

This block decides when a full-duplex Ethernet MAC should emit a PAUSE control frame. It watches how much free space is left in the receive buffer, given in 1 KB units, and compares it with two configurable watermarks. If free space drops under the high watermark, the block requests a pause carrying time FFFFh, which asks the link partner to stop. Once that stop pause has gone out, free space must climb back past the low watermark. At that point the block requests a pause carrying time 0000h, which lets the partner resume. The gap between the two marks provides hysteresis, so the block does not toggle back and forth around a single threshold.

Software can also force either kind of pause with self-clearing command bits. A forced stop always wins over a forced resume. Every request is offered to a transmit engine as a level request with a 16-bit pause time. The request is held until that engine acknowledges it, and only one request is ever outstanding at a time. Building and sending the frame itself is outside this block.

Top module: `pause_watermark_gen`

## Requirements
- R1: After reset the high mark reads 3, the low mark reads 8, and there is no request. Both force-pending bits are clear, and the stop-sent flag is clear.
- R2: The block is idle with flow control and automatic mode enabled, a nonzero high mark, and the stop-sent flag clear. If free space is strictly less than the high mark, a request with time FFFFh appears one clock later. Free space equal to the high mark raises no request.
- R3: With the stop-sent flag set, free space strictly greater than the low mark raises a request with time 0000h one clock later. Free space equal to the low mark raises nothing. Without the flag, no automatic 0000h request is ever made.
- R4: A high mark of 0 suppresses every automatic request.
- R5: With the automatic enable low, no automatic stop request is made. With the flow-control enable low, no new request of any kind is started.
- R6: A pulse on a force input sets its pending bit at the next clock. The pending bit then raises a request with its fixed time: the stop force gives FFFFh and the resume force gives 0000h. The pending bit clears on the clock where that request is acknowledged.
- R7: Forced requests take priority over automatic ones. When both force bits are pending, the FFFFh request is issued first and the 0000h request follows after it.
- R8: Once raised, the request and its time stay unchanged until the acknowledge input is high at a clock edge. The request then drops at that edge. A new request can start no earlier than the following edge.
- R9: The acknowledge of an FFFFh request sets the stop-sent flag. The acknowledge of a 0000h request clears it.
- R10: A configuration write loads both watermarks, which read back from the next clock on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load both watermarks |
| cfg_hi_mark | input | 4 | New high watermark, KB |
| cfg_lo_mark | input | 4 | New low watermark, KB |
| fc_en | input | 1 | Flow-control master enable |
| auto_en | input | 1 | Enable automatic stop on the high mark |
| force_stop_set | input | 1 | Pulse: force an FFFFh pause |
| force_resume_set | input | 1 | Pulse: force a 0000h pause |
| free_kb | input | 5 | Free receive space, KB |
| pause_ack | input | 1 | Transmit engine accepted the request |
| pause_req | output | 1 | Pause request pending |
| pause_time | output | 16 | Pause time of the pending request |
| hi_mark | output | 4 | Current high watermark |
| lo_mark | output | 4 | Current low watermark |
| force_stop_pend | output | 1 | Forced stop pending |
| force_resume_pend | output | 1 | Forced resume pending |
| stop_sent | output | 1 | A stop pause went out and no resume since |

## Verification
The hardest state to reach from the ports is a forced request that competes with an automatic one while the stop-sent flag is already set. The stimulus first completes an automatic stop. It then lowers the flow-control enable and sets a force bit, so the force bit waits while free space sits above the low mark. When the enable returns, the forced FFFFh request must win over the pending automatic resume, and the resume must follow after it. The equal-to-mark boundaries and the rule that a resume needs a prior stop are walked through a stimulus table.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

    typedef enum logic [1:0] {
        K_FSTOP = 2'd0,
        K_FRES  = 2'd1,
        K_ASTOP = 2'd2,
        K_ARES  = 2'd3
    } kind_e;

    localparam int unsigned NUM_SRC = 4;

    function automatic logic is_stop_kind(input kind_e k);
        return (k == K_FSTOP) || (k == K_ASTOP);
    endfunction

endpackage

// File: rtl/pwg_compare.sv
module pwg_compare #(
    parameter int unsigned FREE_W = 5,
    parameter int unsigned MARK_W = 4
) (
    input  logic [FREE_W-1:0] free_kb,
    input  logic [MARK_W-1:0] hi_mark,
    input  logic [MARK_W-1:0] lo_mark,
    output logic              below_hi,
    output logic              above_lo,
    output logic              auto_live
);
    localparam int unsigned CMP_W = (FREE_W > MARK_W) ? FREE_W : MARK_W;

    logic [CMP_W-1:0] free_x;
    logic [CMP_W-1:0] hi_x;
    logic [CMP_W-1:0] lo_x;

    generate
        if (FREE_W > MARK_W) begin : g_wide_free
            assign free_x = free_kb;
            assign hi_x   = {{(CMP_W-MARK_W){1'b0}}, hi_mark};
            assign lo_x   = {{(CMP_W-MARK_W){1'b0}}, lo_mark};
        end else if (FREE_W < MARK_W) begin : g_wide_mark
            assign free_x = {{(CMP_W-FREE_W){1'b0}}, free_kb};
            assign hi_x   = hi_mark;
            assign lo_x   = lo_mark;
        end else begin : g_equal
            assign free_x = free_kb;
            assign hi_x   = hi_mark;
            assign lo_x   = lo_mark;
        end
    endgenerate

    always_comb begin
        auto_live = (hi_mark != '0);
        below_hi  = free_x < hi_x;
        above_lo  = free_x > lo_x;
    end

endmodule

// File: rtl/pwg_arbiter.sv
module pwg_arbiter
    import pwg_pkg::*;
(
    input  logic [NUM_SRC-1:0] cand,
    output logic               grant_valid,
    output kind_e              grant_kind
);
    always_comb begin
        grant_valid = 1'b0;
        grant_kind  = K_FSTOP;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (cand[i]) begin
                grant_valid = 1'b1;
                grant_kind  = kind_e'(i[1:0]);
            end
        end
    end

endmodule

// File: rtl/pause_watermark_gen.sv
module pause_watermark_gen
    import pwg_pkg::*;
#(
    parameter int unsigned FREE_W = 5,
    parameter int unsigned MARK_W = 4,
    parameter int unsigned TIME_W = 16,
    parameter int unsigned HI_RST = 3,
    parameter int unsigned LO_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [MARK_W-1:0] cfg_hi_mark,
    input  logic [MARK_W-1:0] cfg_lo_mark,
    input  logic              fc_en,
    input  logic              auto_en,
    input  logic              force_stop_set,
    input  logic              force_resume_set,
    input  logic [FREE_W-1:0] free_kb,
    input  logic              pause_ack,
    output logic              pause_req,
    output logic [TIME_W-1:0] pause_time,
    output logic [MARK_W-1:0] hi_mark,
    output logic [MARK_W-1:0] lo_mark,
    output logic              force_stop_pend,
    output logic              force_resume_pend,
    output logic              stop_sent
);
    localparam logic [TIME_W-1:0] STOP_TIME = '1;
    localparam logic [TIME_W-1:0] GO_TIME   = '0;
    localparam logic [MARK_W-1:0] HI_INIT   = MARK_W'(HI_RST);
    localparam logic [MARK_W-1:0] LO_INIT   = MARK_W'(LO_RST);

    typedef struct packed {
        logic              req;
        logic [TIME_W-1:0] ptime;
        kind_e             kind;
        logic [MARK_W-1:0] hi;
        logic [MARK_W-1:0] lo;
        logic              fstop;
        logic              fres;
        logic              sent;
    } state_t;

    state_t s_d, s_q;

    logic               below_hi, above_lo, auto_live;
    logic [NUM_SRC-1:0] cand;
    logic               grant_valid;
    kind_e              grant_kind;

    pwg_compare #(.FREE_W(FREE_W), .MARK_W(MARK_W)) u_cmp (
        .free_kb   (free_kb),
        .hi_mark   (s_q.hi),
        .lo_mark   (s_q.lo),
        .below_hi  (below_hi),
        .above_lo  (above_lo),
        .auto_live (auto_live)
    );

    // Index order is the priority order: forced stop, forced resume, auto stop, auto resume
    always_comb begin
        cand          = '0;
        cand[K_FSTOP] = fc_en & s_q.fstop;
        cand[K_FRES]  = fc_en & s_q.fres;
        cand[K_ASTOP] = fc_en & auto_en & auto_live & below_hi & ~s_q.sent;
        cand[K_ARES]  = fc_en & auto_live & s_q.sent & above_lo;
    end

    pwg_arbiter u_arb (
        .cand        (cand),
        .grant_valid (grant_valid),
        .grant_kind  (grant_kind)
    );

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            s_d.hi = cfg_hi_mark;
            s_d.lo = cfg_lo_mark;
        end
        if (s_q.req) begin
            if (pause_ack) begin
                s_d.req  = 1'b0;
                s_d.sent = (s_q.ptime == STOP_TIME);
                if (s_q.kind == K_FSTOP) s_d.fstop = 1'b0;
                if (s_q.kind == K_FRES)  s_d.fres  = 1'b0;
            end
        end else if (grant_valid) begin
            s_d.req   = 1'b1;
            s_d.kind  = grant_kind;
            s_d.ptime = is_stop_kind(grant_kind) ? STOP_TIME : GO_TIME;
        end
        if (force_stop_set)   s_d.fstop = 1'b1;
        if (force_resume_set) s_d.fres  = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.req   <= 1'b0;
            s_q.ptime <= GO_TIME;
            s_q.kind  <= K_FSTOP;
            s_q.hi    <= HI_INIT;
            s_q.lo    <= LO_INIT;
            s_q.fstop <= 1'b0;
            s_q.fres  <= 1'b0;
            s_q.sent  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign pause_req         = s_q.req;
    assign pause_time        = s_q.ptime;
    assign hi_mark           = s_q.hi;
    assign lo_mark           = s_q.lo;
    assign force_stop_pend   = s_q.fstop;
    assign force_resume_pend = s_q.fres;
    assign stop_sent         = s_q.sent;

endmodule

// File: rtl/pause_watermark_gen_chk.sv
module pause_watermark_gen_chk #(
    parameter int unsigned MARK_W = 4,
    parameter int unsigned TIME_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fc_en,
    input logic              force_stop_set,
    input logic              force_resume_set,
    input logic              pause_ack,
    input logic              pause_req,
    input logic [TIME_W-1:0] pause_time,
    input logic [MARK_W-1:0] hi_mark,
    input logic              force_stop_pend,
    input logic              force_resume_pend,
    input logic              stop_sent
);
    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && !pause_ack |=> pause_req && $stable(pause_time));

    // R8
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && pause_ack |=> !pause_req);

    // R9
    stop_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && pause_ack && (pause_time == '1) |=> stop_sent);

    // R9
    resume_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pause_req && pause_ack && (pause_time == '0) |=> !stop_sent);

    // R5
    fc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fc_en && !pause_req |=> !pause_req);

    // R4
    auto_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pause_req && (hi_mark == '0) && !stop_sent
        && !force_stop_pend && !force_resume_pend |=> !pause_req);

    // R6
    fstop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_stop_pend) |-> $past(pause_req && pause_ack && (pause_time == '1)));

    // R6
    fres_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(force_resume_pend) |-> $past(pause_req && pause_ack && (pause_time == '0)));

    // R6
    fset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_stop_set || force_resume_set |=> force_stop_pend || force_resume_pend);

endmodule

bind pause_watermark_gen pause_watermark_gen_chk #(
    .MARK_W (MARK_W),
    .TIME_W (TIME_W)
) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .fc_en             (fc_en),
    .force_stop_set    (force_stop_set),
    .force_resume_set  (force_resume_set),
    .pause_ack         (pause_ack),
    .pause_req         (pause_req),
    .pause_time        (pause_time),
    .hi_mark           (hi_mark),
    .force_stop_pend   (force_stop_pend),
    .force_resume_pend (force_resume_pend),
    .stop_sent         (stop_sent)
);

// File: tb/pause_watermark_gen_tb.sv
module pause_watermark_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_hi_mark = '0;
    logic [3:0]  cfg_lo_mark = '0;
    logic        fc_en = 1'b1;
    logic        auto_en = 1'b1;
    logic        force_stop_set = 1'b0;
    logic        force_resume_set = 1'b0;
    logic [4:0]  free_kb = 5'd10;
    logic        pause_ack = 1'b0;
    logic        pause_req;
    logic [15:0] pause_time;
    logic [3:0]  hi_mark, lo_mark;
    logic        force_stop_pend, force_resume_pend, stop_sent;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pause_watermark_gen u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_hi_mark (cfg_hi_mark), .cfg_lo_mark (cfg_lo_mark),
        .fc_en (fc_en), .auto_en (auto_en),
        .force_stop_set (force_stop_set), .force_resume_set (force_resume_set),
        .free_kb (free_kb), .pause_ack (pause_ack),
        .pause_req (pause_req), .pause_time (pause_time),
        .hi_mark (hi_mark), .lo_mark (lo_mark),
        .force_stop_pend (force_stop_pend), .force_resume_pend (force_resume_pend),
        .stop_sent (stop_sent)
    );

    // {free_kb, ack, exp_req, exp_time, exp_stop_sent}
    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        {5'd10, 1'b0, 1'b0, 16'h0000, 1'b0},
        {5'd3,  1'b0, 1'b0, 16'h0000, 1'b0}, // R2 equal to high mark
        {5'd2,  1'b0, 1'b1, 16'hFFFF, 1'b0}, // R2
        {5'd1,  1'b0, 1'b1, 16'hFFFF, 1'b0}, // R8 held
        {5'd1,  1'b1, 1'b0, 16'h0000, 1'b1}, // R9
        {5'd1,  1'b0, 1'b0, 16'h0000, 1'b1}, // no repeat stop
        {5'd8,  1'b0, 1'b0, 16'h0000, 1'b1}, // R3 equal to low mark
        {5'd9,  1'b0, 1'b1, 16'h0000, 1'b1}, // R3
        {5'd9,  1'b1, 1'b0, 16'h0000, 1'b0}, // R9
        {5'd20, 1'b0, 1'b0, 16'h0000, 1'b0}, // R3 no resume without stop
        {5'd2,  1'b0, 1'b1, 16'hFFFF, 1'b0},
        {5'd2,  1'b1, 1'b0, 16'h0000, 1'b1},
        {5'd31, 1'b0, 1'b1, 16'h0000, 1'b1},
        {5'd31, 1'b1, 1'b0, 16'h0000, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 hi_mark", 32'(hi_mark), 32'd3);
        check("R1 lo_mark", 32'(lo_mark), 32'd8);
        check("R1 req", 32'(pause_req), 0);
        check("R1 pend", 32'({force_stop_pend, force_resume_pend}), 0);
        check("R1 stop_sent", 32'(stop_sent), 0);

        for (int i = 0; i < NV; i++) begin
            free_kb   = VEC[i][23:19];
            pause_ack = VEC[i][18];
            tick();
            check($sformatf("R2 R3 R8 R9 vec %0d req", i), 32'(pause_req), 32'(VEC[i][17]));
            if (VEC[i][17])
                check($sformatf("R2 R3 vec %0d time", i), 32'(pause_time), 32'(VEC[i][16:1]));
            check($sformatf("R9 vec %0d stop_sent", i), 32'(stop_sent), 32'(VEC[i][0]));
        end
        pause_ack = 1'b0;

        // R10 config write
        cfg_we = 1'b1; cfg_hi_mark = 4'd0; cfg_lo_mark = 4'd4;
        tick();
        cfg_we = 1'b0;
        check("R10 hi_mark", 32'(hi_mark), 0);
        check("R10 lo_mark", 32'(lo_mark), 4);
        // R4 high mark zero
        free_kb = 5'd0;
        repeat (3) tick();
        check("R4 no auto req", 32'(pause_req), 0);

        // R5 automatic enable
        cfg_we = 1'b1; cfg_hi_mark = 4'd3; cfg_lo_mark = 4'd8; auto_en = 1'b0;
        tick();
        cfg_we = 1'b0;
        tick();
        check("R5 auto_en off", 32'(pause_req), 0);
        auto_en = 1'b1;
        tick();
        check("R5 auto_en on req", 32'(pause_req), 1);
        check("R5 auto_en on time", 32'(pause_time), 32'hFFFF);
        pause_ack = 1'b1;
        tick();
        pause_ack = 1'b0;
        check("R9 stop_sent", 32'(stop_sent), 1);

        // R5 master enable off, force held pending
        fc_en = 1'b0; free_kb = 5'd15; force_stop_set = 1'b1;
        tick();
        force_stop_set = 1'b0;
        check("R6 stop pend set", 32'(force_stop_pend), 1);
        repeat (2) tick();
        check("R5 fc_en off", 32'(pause_req), 0);
        fc_en = 1'b1;
        tick();
        check("R7 force over auto resume", 32'(pause_time), 32'hFFFF);
        check("R7 req", 32'(pause_req), 1);
        pause_ack = 1'b1;
        tick();
        pause_ack = 1'b0;
        check("R6 stop pend cleared", 32'(force_stop_pend), 0);
        tick();
        check("R3 auto resume req", 32'(pause_req), 1);
        check("R3 auto resume time", 32'(pause_time), 0);
        pause_ack = 1'b1;
        tick();
        pause_ack = 1'b0;
        check("R9 stop_sent cleared", 32'(stop_sent), 0);

        // R7 both forces at once
        free_kb = 5'd5; force_stop_set = 1'b1; force_resume_set = 1'b1;
        tick();
        force_stop_set = 1'b0; force_resume_set = 1'b0;
        check("R6 both pend", 32'({force_stop_pend, force_resume_pend}), 32'b11);
        tick();
        check("R7 first time", 32'(pause_time), 32'hFFFF);
        pause_ack = 1'b1;
        tick();
        pause_ack = 1'b0;
        check("R7 after first", 32'({force_stop_pend, force_resume_pend, pause_req}), 32'b010);
        tick();
        check("R7 second req", 32'(pause_req), 1);
        check("R7 second time", 32'(pause_time), 0);
        pause_ack = 1'b1;
        tick();
        pause_ack = 1'b0;
        check("R6 resume pend cleared", 32'(force_resume_pend), 0);
        check("R9 cleared by forced resume", 32'(stop_sent), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule